// File: doc/BRIEF.md
# Host-Slave Byte Mailbox Port

This block lets an external host processor and a local processor trade bytes through a pair of single-byte mailboxes. The host reaches the port over an asynchronous parallel bus made of a chip select, read and write strobes, one address line and an 8-bit data bus. The local processor sees four byte-wide registers: the inbound mailbox, the outbound mailbox, a status byte and a control byte. Each mailbox has a full flag. A writer is refused while its mailbox is full, so no byte is ever overwritten.

The address line of every accepted host write is kept as a tag bit in the status byte. Local software uses it to tell command bytes from data bytes. The block raises a one-cycle interrupt when the inbound mailbox fills, if interrupts are enabled. It also has a DMA mode, in which software drives the request line and the host's active-low acknowledge is reported in the status byte.

Host strobes are brought into the local clock domain through a synchroniser. Each host access takes effect once, when its strobe is released.

Top module: `hsm_port`

## Requirements
- R1: With the port enabled and the inbound flag clear, a completed host write loads the inbound mailbox from the data bus, sets the inbound flag (status bit 0), and copies the write's address bit into the tag (status bit 2).
- R2: While the inbound flag is set, a host write changes neither the inbound mailbox nor the tag. A local read of address 0 returns the inbound byte and clears the inbound flag.
- R3: A local write to address 1 with the outbound flag clear loads the outbound mailbox and sets the outbound flag (status bit 1). While that flag is set, local writes to address 1 are ignored.
- R4: A host read with address bit 0 drives the outbound byte onto the host data bus. Its completion clears the outbound flag.
- R5: A host read with address bit 1 drives the status byte onto the host data bus and changes no flag.
- R6: When the interrupt-enable bit (control bit 1) is 1, the interrupt output pulses for one cycle as the inbound flag becomes set. When that bit is 0, the output stays low.
- R7: While the port-enable bit (control bit 0) is 0, both flags read 0 and host and local transfers are refused. Local writes to the status address (2) change no flag.
- R8: Writing control with the DMA bit (bit 2) set while DMA mode was off leaves the request output low. In DMA mode the request output follows the request bit (bit 3). Clearing the DMA bit or the enable bit drops the request output and ends DMA mode.
- R9: The active-low acknowledge input, after synchronisation, appears as status bit 3 (1 while acknowledged).
- R10: If a host mailbox access and a local access to the same full mailbox complete in the same cycle, the flag is cleared and the local write is refused. The same holds for a host write refused against a local inbound read.
- R11: After reset, flags, tag, control byte, request and interrupt outputs are all 0.
- R12: A host strobe held active for many cycles counts as exactly one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_a0 | input | 1 | Host address bit: read selects outbound/status, write tag |
| host_din | input | DW | Host write data |
| host_dout | output | DW | Registered host read data |
| host_doe | output | 1 | Registered host data drive enable |
| loc_addr | input | 2 | Local register address: 0 inbound, 1 outbound, 2 status, 3 control |
| loc_rd | input | 1 | Local read strobe, data one cycle later |
| loc_wr | input | 1 | Local write strobe |
| loc_wdata | input | DW | Local write data |
| loc_rdata | output | DW | Registered local read data |
| ibf_irq | output | 1 | Inbound-full interrupt pulse |
| dma_req | output | 1 | DMA request |
| dma_ack_n | input | 1 | DMA acknowledge, active low |

## Verification
Two pairs of functions can fall in the same cycle. A host read that drains the outbound mailbox can land with a local write to it. A host write can land with a local read that empties the inbound mailbox. The bench releases the host strobe and then places the local access at the exact negative edge before the synchroniser's completion edge. It judges the result from the status flags read afterwards, from the byte the host receives on a later read, and from the byte the local side reads back.

// File: rtl/hsm_pkg.sv
package hsm_pkg;
  localparam int LADDR_W = 2;

  typedef enum logic [LADDR_W-1:0] {
    LA_INBOX  = 2'd0,
    LA_OUTBOX = 2'd1,
    LA_STATUS = 2'd2,
    LA_CONTROL = 2'd3
  } loc_addr_e;

  // status byte bit positions
  localparam int ST_IBF = 0;
  localparam int ST_OBF = 1;
  localparam int ST_TAG = 2;
  localparam int ST_ACK = 3;

  // control byte bit positions
  localparam int CT_EN  = 0;
  localparam int CT_IE  = 1;
  localparam int CT_DMA = 2;
  localparam int CT_DRQ = 3;
  localparam int CT_W   = 4;
endpackage

// File: rtl/hsm_sync.sv
module hsm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic level
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], async_in};
  end

  assign level = sh[STAGES-1];
endmodule

// File: rtl/hsm_mailbox.sv
module hsm_mailbox #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          host_wr_done,
  input  logic          host_wr_a0,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_ob_rd,
  input  logic          loc_in_rd,
  input  logic          loc_out_wr,
  input  logic [DW-1:0] loc_wdata,
  output logic [DW-1:0] inbox,
  output logic [DW-1:0] outbox,
  output logic          ibf,
  output logic          obf,
  output logic          tag,
  output logic          ibf_set
);
  logic out_ok;

  assign ibf_set = en & host_wr_done & ~ibf;
  assign out_ok  = en & loc_out_wr & ~obf;

  always_ff @(posedge clk) begin
    if (rst) begin
      inbox  <= '0;
      outbox <= '0;
      tag    <= 1'b0;
      ibf    <= 1'b0;
      obf    <= 1'b0;
    end else begin
      if (ibf_set) begin
        inbox <= host_wdata;
        tag   <= host_wr_a0;
      end
      if (out_ok) outbox <= loc_wdata;

      if (!en)            ibf <= 1'b0;
      else if (ibf_set)   ibf <= 1'b1;
      else if (loc_in_rd) ibf <= 1'b0;

      if (!en)             obf <= 1'b0;
      else if (out_ok)     obf <= 1'b1;
      else if (host_ob_rd) obf <= 1'b0;
    end
  end

  AST_INBOX_LOCKED: assert property (@(posedge clk) disable iff (rst)
    ibf && host_wr_done |=> $stable(inbox) && $stable(tag)); // R2
  AST_OUTBOX_LOCKED: assert property (@(posedge clk) disable iff (rst)
    obf && loc_out_wr |=> $stable(outbox)); // R3
  AST_FLAGS_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en |=> !ibf && !obf); // R7
  AST_OUTBOX_DRAIN: assert property (@(posedge clk) disable iff (rst)
    en && host_ob_rd && (obf || !loc_out_wr) |=> !obf); // R10
endmodule

// File: rtl/hsm_ctrl.sv
module hsm_ctrl
  import hsm_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            ctl_wr,
  input  logic [CT_W-1:0] ctl_fields,
  input  logic            ibf_set,
  output logic            en,
  output logic            ie,
  output logic            dma,
  output logic            drq,
  output logic            irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en  <= 1'b0;
      ie  <= 1'b0;
      dma <= 1'b0;
      drq <= 1'b0;
      irq <= 1'b0;
    end else begin
      irq <= ibf_set & ie;
      if (ctl_wr) begin
        en  <= ctl_fields[CT_EN];
        ie  <= ctl_fields[CT_IE];
        dma <= ctl_fields[CT_DMA] & ctl_fields[CT_EN];
        drq <= ctl_fields[CT_DRQ] & ctl_fields[CT_DMA] & ctl_fields[CT_EN] & dma;
      end
    end
  end

  AST_DRQ_IN_MODE: assert property (@(posedge clk) disable iff (rst)
    drq |-> dma && en); // R8
  AST_DMA_ENTRY_LOW: assert property (@(posedge clk) disable iff (rst)
    ctl_wr && !dma && ctl_fields[CT_DMA] |=> !drq); // R8
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ie)); // R6
endmodule

// File: rtl/hsm_port.sv
module hsm_port
  import hsm_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_cs_n,
  input  logic               host_rd_n,
  input  logic               host_wr_n,
  input  logic               host_a0,
  input  logic [DW-1:0]      host_din,
  output logic [DW-1:0]      host_dout,
  output logic               host_doe,
  input  logic [LADDR_W-1:0] loc_addr,
  input  logic               loc_rd,
  input  logic               loc_wr,
  input  logic [DW-1:0]      loc_wdata,
  output logic [DW-1:0]      loc_rdata,
  output logic               ibf_irq,
  output logic               dma_req,
  input  logic               dma_ack_n
);
  localparam int NSYNC = 3; // 0 read strobe, 1 write strobe, 2 acknowledge

  logic [NSYNC-1:0] raw_act, lvl;
  logic [1:0]       lvl_q, done;
  logic             a0_q;
  logic [DW-1:0]    din_q;

  assign raw_act = {~dma_ack_n, ~host_cs_n & ~host_wr_n, ~host_cs_n & ~host_rd_n};

  for (genvar g = 0; g < NSYNC; g++) begin : g_sync
    hsm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .async_in(raw_act[g]), .level(lvl[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= '0;
      a0_q  <= 1'b0;
      din_q <= '0;
    end else begin
      lvl_q <= lvl[1:0];
      a0_q  <= host_a0;
      din_q <= host_din;
    end
  end

  assign done = lvl_q & ~lvl[1:0];

  logic          en, ie, dma, drq, irq;
  logic          ibf, obf, tag, ibf_set;
  logic [DW-1:0] inbox, outbox, status, control;
  logic          loc_in_rd, loc_out_wr, ctl_wr, host_ob_rd;

  assign loc_in_rd  = loc_rd & (loc_addr == LA_INBOX);
  assign loc_out_wr = loc_wr & (loc_addr == LA_OUTBOX);
  assign ctl_wr     = loc_wr & (loc_addr == LA_CONTROL);
  assign host_ob_rd = done[0] & ~a0_q;

  hsm_mailbox #(.DW(DW)) u_mbox (
    .clk(clk), .rst(rst), .en(en),
    .host_wr_done(done[1]), .host_wr_a0(a0_q), .host_wdata(din_q),
    .host_ob_rd(host_ob_rd), .loc_in_rd(loc_in_rd), .loc_out_wr(loc_out_wr),
    .loc_wdata(loc_wdata), .inbox(inbox), .outbox(outbox),
    .ibf(ibf), .obf(obf), .tag(tag), .ibf_set(ibf_set)
  );

  hsm_ctrl u_ctrl (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_fields(loc_wdata[CT_W-1:0]),
    .ibf_set(ibf_set), .en(en), .ie(ie), .dma(dma), .drq(drq), .irq(irq)
  );

  always_comb begin
    status = '0;
    status[ST_IBF] = ibf;
    status[ST_OBF] = obf;
    status[ST_TAG] = tag;
    status[ST_ACK] = lvl[2];
    control = '0;
    control[CT_EN]  = en;
    control[CT_IE]  = ie;
    control[CT_DMA] = dma;
    control[CT_DRQ] = drq;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_dout <= '0;
      host_doe  <= 1'b0;
      loc_rdata <= '0;
    end else begin
      host_dout <= host_a0 ? status : outbox;
      host_doe  <= ~host_cs_n & ~host_rd_n;
      if (loc_rd) begin
        case (loc_addr)
          LA_INBOX:  loc_rdata <= inbox;
          LA_OUTBOX: loc_rdata <= outbox;
          LA_STATUS: loc_rdata <= status;
          default:   loc_rdata <= control;
        endcase
      end
    end
  end

  assign ibf_irq = irq;
  assign dma_req = drq;

  AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
    ibf_irq |-> ibf); // R6
  AST_STATUS_READ_QUIET: assert property (@(posedge clk) disable iff (rst)
    done[0] && a0_q && !done[1] && !loc_in_rd && !loc_out_wr && !ctl_wr
    |=> $stable(ibf) && $stable(obf)); // R5
  AST_SINGLE_DONE: assert property (@(posedge clk) disable iff (rst)
    done[1] |=> !done[1]); // R12
endmodule

// File: tb/hsm_port_bench.sv
module hsm_port_bench;
  localparam int DW = 8;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          host_cs_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1, host_a0 = 1'b0;
  logic [DW-1:0] host_din = '0;
  logic [DW-1:0] host_dout, loc_rdata;
  logic          host_doe, ibf_irq, dma_req;
  logic [1:0]    loc_addr = '0;
  logic          loc_rd = 1'b0, loc_wr = 1'b0;
  logic [DW-1:0] loc_wdata = '0;
  logic          dma_ack_n = 1'b1;

  hsm_port #(.DW(DW), .SYNC_STAGES(SYNC)) u_hsm_port (
    .clk(clk), .rst(rst), .host_cs_n(host_cs_n), .host_rd_n(host_rd_n),
    .host_wr_n(host_wr_n), .host_a0(host_a0), .host_din(host_din),
    .host_dout(host_dout), .host_doe(host_doe), .loc_addr(loc_addr),
    .loc_rd(loc_rd), .loc_wr(loc_wr), .loc_wdata(loc_wdata),
    .loc_rdata(loc_rdata), .ibf_irq(ibf_irq), .dma_req(dma_req),
    .dma_ack_n(dma_ack_n)
  );

  int vectors = 0;
  int errs = 0;
  int irq_cnt = 0;
  logic [DW-1:0] exp_q[$];
  string         req_q[$];
  logic          rv_tb = 1'b0;

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    vectors++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  // scoreboard monitor for local reads: data is due one cycle after the strobe
  always @(posedge clk) rv_tb <= loc_rd;
  always @(negedge clk) begin
    if (irq_cnt >= 0 && ibf_irq) irq_cnt++;
    if (rv_tb) begin
      if (exp_q.size() == 0) begin
        errs++;
        $display("FAIL scoreboard: unexpected read data %02h expected none", loc_rdata);
      end else begin
        check(req_q.pop_front(), loc_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic loc_read(input logic [1:0] a, input logic [DW-1:0] exp, input string req);
    @(negedge clk);
    exp_q.push_back(exp); req_q.push_back(req);
    loc_addr = a; loc_rd = 1'b1;
    @(negedge clk);
    loc_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic loc_write(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    loc_addr = a; loc_wdata = d; loc_wr = 1'b1;
    @(negedge clk);
    loc_wr = 1'b0;
  endtask

  // col: 0 none, 1 local outbox write at completion, 2 local inbox read at completion
  task automatic host_write(input logic a0, input logic [DW-1:0] d, input int hold,
                            input int col, input logic [DW-1:0] col_exp);
    @(negedge clk);
    host_cs_n = 1'b0; host_a0 = a0; host_din = d; host_wr_n = 1'b0;
    repeat (hold) @(negedge clk);
    host_wr_n = 1'b1;
    repeat (SYNC) @(negedge clk);
    if (col == 2) begin
      exp_q.push_back(col_exp); req_q.push_back("R10 inbox read at write completion");
      loc_addr = 2'd0; loc_rd = 1'b1;
    end
    @(negedge clk);
    loc_rd = 1'b0;
    repeat (4) @(negedge clk);
    host_cs_n = 1'b1;
  endtask

  task automatic host_read(input logic a0, input logic [DW-1:0] exp, input string req,
                           input int col, input logic [DW-1:0] col_d);
    @(negedge clk);
    host_cs_n = 1'b0; host_a0 = a0; host_rd_n = 1'b0;
    repeat (4) @(negedge clk);
    check(req, host_dout, exp);
    host_rd_n = 1'b1;
    repeat (SYNC) @(negedge clk);
    if (col == 1) begin
      loc_addr = 2'd1; loc_wdata = col_d; loc_wr = 1'b1;
    end
    @(negedge clk);
    loc_wr = 1'b0;
    repeat (4) @(negedge clk);
    host_cs_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    int c0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 request after reset", {7'd0, dma_req}, 8'h00);
    check("R11 interrupt after reset", {7'd0, ibf_irq}, 8'h00);
    loc_read(2'd2, 8'h00, "R11 status after reset");
    loc_read(2'd3, 8'h00, "R11 control after reset");

    loc_write(2'd3, 8'h03); // enable + interrupt enable
    c0 = irq_cnt;
    // R1 write with tag 1, held many cycles (R12)
    host_write(1'b1, 8'hA5, 12, 0, 8'h00);
    loc_read(2'd2, 8'h05, "R1 status after host command write");
    check("R6 one interrupt pulse", 8'(irq_cnt - c0), 8'h01);
    check("R12 long strobe counts once", 8'(irq_cnt - c0), 8'h01);
    // R2 refused write
    host_write(1'b0, 8'h3C, 3, 0, 8'h00);
    loc_read(2'd2, 8'h05, "R2 tag and flag after refused write");
    loc_read(2'd0, 8'hA5, "R2 inbox unchanged by refused write");
    loc_read(2'd2, 8'h04, "R2 inbound flag cleared by local read");
    host_write(1'b0, 8'h3C, 3, 0, 8'h00);
    loc_read(2'd2, 8'h01, "R1 data write tag 0");
    loc_read(2'd0, 8'h3C, "R1 inbox data");

    // R3 / R4 / R5
    loc_write(2'd1, 8'h5A);
    host_read(1'b1, 8'h02, "R5 host status read", 0, 8'h00);
    host_read(1'b1, 8'h02, "R5 status read leaves flags", 0, 8'h00);
    loc_write(2'd1, 8'h77);
    host_read(1'b0, 8'h5A, "R3 outbox keeps first byte", 0, 8'h00);
    loc_read(2'd2, 8'h00, "R4 outbound flag cleared by host read");

    // R10 collisions
    loc_write(2'd1, 8'h11);
    host_read(1'b0, 8'h11, "R10 host read before collision", 1, 8'h22);
    loc_read(2'd2, 8'h00, "R10 outbound flag clear after collision");
    loc_read(2'd1, 8'h11, "R10 colliding local write refused");
    host_write(1'b0, 8'h44, 3, 0, 8'h00);
    host_write(1'b1, 8'h99, 3, 2, 8'h44);
    loc_read(2'd2, 8'h00, "R10 inbound flag clear, write refused");
    loc_read(2'd0, 8'h44, "R10 inbox not overwritten");

    // R6 interrupt disabled
    loc_write(2'd3, 8'h01);
    c0 = irq_cnt;
    host_write(1'b0, 8'h10, 3, 0, 8'h00);
    check("R6 no pulse with interrupt disabled", 8'(irq_cnt - c0), 8'h00);
    loc_read(2'd2, 8'h01, "R6 flag still sets without interrupt");

    // R7 disable
    loc_write(2'd1, 8'h33);
    loc_write(2'd3, 8'h00);
    loc_read(2'd2, 8'h00, "R7 flags cleared while disabled");
    loc_write(2'd2, 8'hFF);
    host_write(1'b1, 8'h66, 3, 0, 8'h00);
    loc_write(2'd1, 8'h55);
    loc_write(2'd3, 8'h01);
    loc_read(2'd2, 8'h00, "R7 transfers refused while disabled");
    loc_read(2'd0, 8'h10, "R7 inbox untouched while disabled");

    // R8 DMA request
    loc_write(2'd3, 8'h0D);
    @(negedge clk); check("R8 entry leaves request low", {7'd0, dma_req}, 8'h00);
    loc_write(2'd3, 8'h0D);
    @(negedge clk); check("R8 request asserted in mode", {7'd0, dma_req}, 8'h01);
    loc_write(2'd3, 8'h05);
    @(negedge clk); check("R8 request follows bit", {7'd0, dma_req}, 8'h00);
    loc_write(2'd3, 8'h0D);
    @(negedge clk); check("R8 request reasserted", {7'd0, dma_req}, 8'h01);
    loc_write(2'd3, 8'h09);
    @(negedge clk); check("R8 leaving mode drops request", {7'd0, dma_req}, 8'h00);
    loc_write(2'd3, 8'h05);
    loc_write(2'd3, 8'h0D);
    loc_write(2'd3, 8'h0C);
    @(negedge clk); check("R8 disable drops request", {7'd0, dma_req}, 8'h00);
    loc_read(2'd3, 8'h00, "R8 disable ends mode");

    // R9 acknowledge
    @(negedge clk); dma_ack_n = 1'b0;
    repeat (SYNC + 2) @(negedge clk);
    loc_read(2'd2, 8'h08, "R9 acknowledge visible");
    dma_ack_n = 1'b1;
    repeat (SYNC + 2) @(negedge clk);
    loc_read(2'd2, 8'h00, "R9 acknowledge released");

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule